// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A 4-bit synchronous up-counter with a parallel preset path, built to be chained into wider synchronous counters. On each rising clock edge the state is cleared, loaded from a parallel data input, incremented, or left alone. These outcomes are ranked, and the highest-ranked one whose condition holds wins. After state fifteen the count wraps back to zero.

Two active-high count enables control the increment, and each has its own role. The shared enable advances every stage of a chain together. The trickle enable carries the carry from one stage to the next. The terminal-count flag depends on the trickle enable only. So when each stage's flag drives the next stage's trickle enable, N stages count as one binary counter of 4×N bits.

A parameter selects the reset style. The default is an active-low asynchronous clear that acts without waiting for the clock. The other setting is an active-low clear that acts on the next rising edge.

Top module: `presettable_counter`

## Requirements
- R1: Counting is modulo 2^WIDTH in binary. With WIDTH=4, an increment from 15 gives 0.
- R2: Reset ranks above load, load ranks above count, and count ranks above hold. While reset is low, neither the load input nor the enables change the cleared state.
- R3: With SYNC_RESET=0 (the default), a low on rstN forces countOut to 0 at once, without a clock edge.
- R4: With SYNC_RESET=1, a low on rstN leaves countOut unchanged until the next rising edge, which then sets it to 0.
- R5: With rstN high and loadN low, the next rising edge copies dataIn into the state, whatever cntEnPar and cntEnTrk are.
- R6: With rstN and loadN high and both cntEnPar and cntEnTrk high, the next rising edge adds one to the state.
- R7: With rstN and loadN high and either count enable low, the state holds across rising edges.
- R8: termCount is high exactly when cntEnTrk is high and the state is all ones. It is combinational and does not depend on cntEnPar.
- R9: Three stages that share cntEnPar, with each termCount feeding the next stage's cntEnTrk, behave as one 12-bit counter. The last stage's termCount marks the value 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low clear; asynchronous or synchronous per SYNC_RESET |
| loadN | input | 1 | Active-low parallel load enable |
| dataIn | input | WIDTH | Parallel preset value |
| cntEnPar | input | 1 | Shared count enable; does not affect termCount |
| cntEnTrk | input | 1 | Trickle count enable; also qualifies termCount |
| countOut | output | WIDTH | Current counter state |
| termCount | output | 1 | High when cntEnTrk is high and the state is all ones |

## Verification
The bench builds two cascades of three stages each, both with WIDTH=4. One uses SYNC_RESET=0 and the other uses SYNC_RESET=1, and both receive the same stimulus. This lets a single reset pulse that falls in the middle of a cycle show the immediate clear in one chain and the clear deferred to the next edge in the other. With 12-bit chains, a full sweep of 4096 states is short. It covers every stage-to-stage carry and the wrap from 4095 to 0, and it checks each step against a 12-bit arithmetic model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef struct packed {
    logic clearNow;
    logic loadNow;
    logic stepNow;
  } cntStrobes_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadN,
  input  logic        cntEnPar,
  input  logic        cntEnTrk,
  output cntStrobes_t strobes
);
  logic clearReq;

  generate
    if (SYNC_RESET) begin : g_syncClear
      assign clearReq = ~rstN;
    end else begin : g_asyncClear
      // the asynchronous clear is applied directly in the datapath register
      assign clearReq = 1'b0;
    end
  endgenerate

  // fixed ranking: clear, then load, then step, then hold
  always_comb begin
    strobes          = '0;
    strobes.clearNow = clearReq;
    strobes.loadNow  = ~clearReq & ~loadN;
    strobes.stepNow  = ~clearReq & loadN & cntEnPar & cntEnTrk;
  end

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clearNow, strobes.loadNow, strobes.stepNow})); // R2
  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |-> !strobes.stepNow); // R5
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  input  logic [WIDTH-1:0] loadData,
  input  logic             trkEn,
  output logic [WIDTH-1:0] state,
  output logic             termCount
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] nextState;

  always_comb begin
    if (strobes.clearNow)     nextState = '0;
    else if (strobes.loadNow) nextState = loadData;
    else if (strobes.stepNow) nextState = state + ONE;
    else                      nextState = state;
  end

  generate
    if (SYNC_RESET) begin : g_syncReg
      always_ff @(posedge clk) state <= nextState;
    end else begin : g_asyncReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) state <= '0;
        else       state <= nextState;
      end
    end
  endgenerate

  assign termCount = trkEn & (state == ALL_ONES);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> state == $past(loadData)); // R5
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepNow |=> state == $past(state) + ONE); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && state == ALL_ONES) |=> state == '0); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clearNow || strobes.loadNow || strobes.stepNow) |=> $stable(state)); // R7
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             cntEnPar,
  input  logic             cntEnTrk,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);
  cntStrobes_t strobes;

  cnt_ctrl #(.SYNC_RESET(SYNC_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadN(loadN),
    .cntEnPar(cntEnPar), .cntEnTrk(cntEnTrk), .strobes(strobes)
  );

  cnt_datapath #(.WIDTH(WIDTH), .SYNC_RESET(SYNC_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(dataIn),
    .trkEn(cntEnTrk), .state(countOut), .termCount(termCount)
  );

  AST_TC_NEEDS_TRK: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> (cntEnTrk && countOut == '1)); // R8
  AST_TC_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (cntEnTrk && countOut == '1) |-> termCount); // R8

  generate
    if (SYNC_RESET) begin : g_syncChk
      AST_SYNC_CLEAR: assert property (@(posedge clk)
        !rstN |=> countOut == '0); // R4
    end else begin : g_asyncChk
      AST_ASYNC_CLEAR: assert property (@(posedge clk)
        !rstN |-> countOut == '0); // R3
    end
  endgenerate
endmodule

// File: tb/test_presettable_counter.sv
`timescale 1ns/1ps
module test_presettable_counter;
  localparam int W  = 4;
  localparam int N  = 3;
  localparam int TW = W * N;
  localparam logic [TW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0, loadN = 1'b1, parEn = 1'b0, trkEn = 1'b0;
  logic [TW-1:0] dataIn = '0;
  logic [TW-1:0] cntA, cntS, refV;
  logic [N:0] tcA, tcS;
  int testCnt = 0, failCnt = 0;

  always #2 clk = ~clk;

  assign tcA[0] = trkEn;
  assign tcS[0] = trkEn;

  for (genvar g = 0; g < N; g++) begin : stageA
    presettable_counter #(.WIDTH(W), .SYNC_RESET(1'b0)) i_presettable_counter (
      .clk(clk), .rstN(rstN), .loadN(loadN), .dataIn(dataIn[g*W +: W]),
      .cntEnPar(parEn), .cntEnTrk(tcA[g]),
      .countOut(cntA[g*W +: W]), .termCount(tcA[g+1]));
  end
  for (genvar g = 0; g < N; g++) begin : stageS
    presettable_counter #(.WIDTH(W), .SYNC_RESET(1'b1)) i_presettable_counter (
      .clk(clk), .rstN(rstN), .loadN(loadN), .dataIn(dataIn[g*W +: W]),
      .cntEnPar(parEn), .cntEnTrk(tcS[g]),
      .countOut(cntS[g*W +: W]), .termCount(tcS[g+1]));
  end

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN)       refV = '0;
    else if (!loadN) refV = dataIn;
    else if (parEn && trkEn) refV = refV + 1'b1;
    @(negedge clk);
  endtask

  task automatic chkBoth(input string tag);
    chk({tag, " async"}, cntA, refV);
    chk({tag, " sync"}, cntS, refV);
    chk({tag, " tc async"}, TW'(tcA[N]), TW'(trkEn && refV == TOP));
    chk({tag, " tc sync"}, TW'(tcS[N]), TW'(trkEn && refV == TOP));
  endtask

  initial begin
    #800000;
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    refV = '0;
    tick(); tick();
    chkBoth("R2 reset state");

    // full sweep through the 12-bit chain, crossing every carry and the wrap
    rstN = 1'b1; parEn = 1'b1; trkEn = 1'b1;
    for (int i = 0; i < 4100; i++) begin
      tick();
      chkBoth("R1 R6 R8 R9 sweep");
    end

    // load beats count, and works with enables low
    loadN = 1'b0; dataIn = 12'hABC;
    tick(); chkBoth("R5 load while counting");
    parEn = 1'b0; trkEn = 1'b0; dataIn = 12'h123;
    tick(); chkBoth("R5 load enables low");
    loadN = 1'b1;

    // hold with each enable low in turn
    parEn = 1'b0; trkEn = 1'b1;
    for (int i = 0; i < 3; i++) begin tick(); chkBoth("R7 hold par low"); end
    parEn = 1'b1; trkEn = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(); chkBoth("R7 hold trk low"); end

    // terminal count is independent of the shared enable
    loadN = 1'b0; dataIn = TOP; tick(); loadN = 1'b1;
    parEn = 1'b0; trkEn = 1'b1; #1;
    chk("R8 tc with par low", TW'(tcA[N]), TW'(1));
    chk("R8 stage0 tc with par low", TW'(tcS[1]), TW'(1));
    trkEn = 1'b0; #1;
    chk("R8 tc drops with trk", TW'(tcA[N]), TW'(0));
    chk("R8 stage0 tc drops with trk", TW'(tcS[1]), TW'(0));
    @(negedge clk);
    parEn = 1'b1; trkEn = 1'b1;
    tick(); chkBoth("R1 R9 wrap after load");

    // reset during load and count
    loadN = 1'b0; dataIn = 12'h555; rstN = 1'b0;
    tick(); chkBoth("R2 reset beats load");
    rstN = 1'b1; dataIn = 12'h777;
    tick(); chkBoth("R5 load after reset");
    loadN = 1'b1; parEn = 1'b0;

    // reset falling mid-cycle
    #1 rstN = 1'b0;
    #0.5;
    chk("R3 async clears at once", cntA, '0);
    chk("R4 sync waits for edge", cntS, 12'h777);
    tick();
    chk("R4 sync clears on edge", cntS, '0);
    chk("R3 async stays clear", cntA, '0);
    rstN = 1'b1; parEn = 1'b1;
    tick(); chkBoth("R6 count after reset");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule